// File: doc/BRIEF.md
# Switch-Configurable Memory Block Selector

This block turns the upper lines of a 16-bit address bus into one low-true chip select. A small switch word gives, for each of the upper address lines, the level that line must have for the select to fire. A 2-bit size code sets how many of those upper lines take part in the comparison, so the same block can carve the address space into 8K, 4K, 2K or 1K pieces without any change to the logic around it.

The block has no state. The select follows the address, switch and size inputs directly. A build-time option can also AND the match with the phase-2 clock. The select then only goes active while phase 2 is high, which moves the write strobe timing onto the chip select itself. Memory contents and bus driving are handled elsewhere.

Top module: `blksel_top`

## Requirements
- R1: The size code picks the number of compared upper lines: 00 compares 3 lines (8K blocks), 01 compares 4 (4K), 10 compares 5 (2K) and 11 compares 6 (1K).
- R2: Switch bit 5 pairs with address bit 15, bit 4 with bit 14, and so on down to switch bit 0 with address bit 10. When every compared line equals its switch bit (and gating permits), `blk_sel_n` is 0.
- R3: A mismatch on any single compared line forces `blk_sel_n` to 1.
- R4: Address lines below the compared range have no effect on `blk_sel_n`.
- R5: Switch bits below the compared range have no effect on `blk_sel_n`.
- R6: With size code 11 and switch word 000100, the select is active exactly for addresses 0x1000 through 0x13FF.
- R7: With phase-2 gating built in (`GATE_PHI2`=1), `blk_sel_n` is 1 whenever `phi2` is 0, and equals the inverted match whenever `phi2` is 1.
- R8: With phase-2 gating left out (`GATE_PHI2`=0), `phi2` has no effect on `blk_sel_n`.
- R9: The output is purely combinational. It reflects a change on any input within the same clock period, with no clock edge needed, and it is never unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Address bus |
| sw_pol | input | 6 | Required level for each upper address line, bit 5 for the top line |
| size_code | input | 2 | Block size select: 00 8K, 01 4K, 10 2K, 11 1K |
| phi2 | input | 1 | Phase-2 clock, used only when gating is built in |
| blk_sel_n | output | 1 | Low-true block select |

## Verification
The case that is hardest to reach from the ports is a near-miss: every compared line matches except the lowest one in the current range, and the next line down, which is not compared, mismatches. Uniform random stimulus almost never lands there. The bench therefore builds addresses that match the switch word on all six upper lines, then flips exactly one chosen upper bit. It steps the flipped position across and just beyond the compared range for every size code, which covers both the size boundary and the single-mismatch rule.

// File: rtl/blksel_pkg.sv
package blksel_pkg;
    localparam int SIZE_W = 2;

    typedef enum logic [SIZE_W-1:0] {
        BLK_8K = 2'b00,
        BLK_4K = 2'b01,
        BLK_2K = 2'b10,
        BLK_1K = 2'b11
    } blk_size_e;

    typedef struct packed {
        logic hit;
        logic sel_n;
    } sel_state_t;
endpackage

// File: rtl/blksel_mask.sv
module blksel_mask
    import blksel_pkg::*;
#(
    parameter int MIN_LINES = 3,
    localparam int MAX_LINES = MIN_LINES + (1 << SIZE_W) - 1
) (
    input  logic [SIZE_W-1:0]    size_code,
    output logic [MAX_LINES-1:0] cmp_mask
);
    // line k counts from the top address line; it is compared when k < MIN_LINES + size
    for (genvar k = 0; k < MAX_LINES; k++) begin : g_line
        if (k < MIN_LINES) begin : g_fixed
            assign cmp_mask[MAX_LINES-1-k] = 1'b1;
        end else begin : g_sized
            assign cmp_mask[MAX_LINES-1-k] = (int'(size_code) >= (k - MIN_LINES + 1));
        end
    end
endmodule

// File: rtl/blksel_match.sv
module blksel_match #(
    parameter int LINES = 6
) (
    input  logic [LINES-1:0] addr_top,
    input  logic [LINES-1:0] sw_pol,
    input  logic [LINES-1:0] cmp_mask,
    output logic             hit
);
    logic [LINES-1:0] line_ok;

    for (genvar j = 0; j < LINES; j++) begin : g_cmp
        assign line_ok[j] = ~(addr_top[j] ^ sw_pol[j]) | ~cmp_mask[j];
    end

    assign hit = &line_ok;
endmodule

// File: rtl/blksel_qual.sv
module blksel_qual #(
    parameter bit GATE_PHI2 = 1'b1
) (
    input  logic hit,
    input  logic phi2,
    output logic sel_n
);
    if (GATE_PHI2) begin : g_gated
        assign sel_n = ~(hit & phi2);
    end else begin : g_plain
        logic unused_phi2;
        assign unused_phi2 = phi2;
        assign sel_n = ~hit;
    end
endmodule

// File: rtl/blksel_top.sv
module blksel_top
    import blksel_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MIN_LINES = 3,
    parameter bit GATE_PHI2 = 1'b1,
    localparam int MAX_LINES = MIN_LINES + (1 << SIZE_W) - 1
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [MAX_LINES-1:0] sw_pol,
    input  logic [SIZE_W-1:0]    size_code,
    input  logic                 phi2,
    output logic                 blk_sel_n
);
    logic [MAX_LINES-1:0] addr_top;
    logic [MAX_LINES-1:0] cmp_mask;
    logic                 hit;
    logic                 qual_n;
    logic                 unused_low;
    sel_state_t           sel_d;

    assign addr_top   = addr[ADDR_W-1 -: MAX_LINES];
    assign unused_low = ^addr[ADDR_W-MAX_LINES-1:0];

    blksel_mask #(.MIN_LINES(MIN_LINES)) u_mask (
        .size_code (size_code),
        .cmp_mask  (cmp_mask)
    );

    blksel_match #(.LINES(MAX_LINES)) u_match (
        .addr_top (addr_top),
        .sw_pol   (sw_pol),
        .cmp_mask (cmp_mask),
        .hit      (hit)
    );

    blksel_qual #(.GATE_PHI2(GATE_PHI2)) u_qual (
        .hit   (hit),
        .phi2  (phi2),
        .sel_n (qual_n)
    );

    // no registered state: the next-value struct drives the port directly
    always_comb begin
        sel_d.hit   = hit;
        sel_d.sel_n = qual_n;
    end

    assign blk_sel_n = sel_d.sel_n;
endmodule

// File: rtl/blksel_chk.sv
module blksel_chk #(
    parameter int ADDR_W    = 16,
    parameter int MIN_LINES = 3,
    parameter bit GATE_PHI2 = 1'b1,
    localparam int MAX_LINES = MIN_LINES + 3
) (
    input logic [ADDR_W-1:0]    addr,
    input logic [MAX_LINES-1:0] sw_pol,
    input logic [1:0]           size_code,
    input logic                 phi2,
    input logic                 blk_sel_n
);
    always_comb begin
        assert_known_R9: assert (!$isunknown(blk_sel_n))
            else $error("select unknown");
        if (!blk_sel_n) begin
            // R2: the always-compared top lines must agree with the switches
            assert_top_match_R2: assert (addr[ADDR_W-1 -: MIN_LINES] == sw_pol[MAX_LINES-1 -: MIN_LINES])
                else $error("select active with top-line mismatch");
            if (size_code != 2'b00) begin
                assert_fourth_line_R3: assert (addr[ADDR_W-MIN_LINES-1] == sw_pol[MAX_LINES-MIN_LINES-1])
                    else $error("select active with fourth-line mismatch");
            end
            if (size_code == 2'b11) begin
                assert_last_line_R1: assert (addr[ADDR_W-MAX_LINES] == sw_pol[0])
                    else $error("1K select active with lowest-line mismatch");
            end
        end
        if (GATE_PHI2 && !phi2) begin
            assert_gate_low_R7: assert (blk_sel_n)
                else $error("select active while phase 2 low");
        end
    end
endmodule

bind blksel_top blksel_chk #(
    .ADDR_W    (ADDR_W),
    .MIN_LINES (MIN_LINES),
    .GATE_PHI2 (GATE_PHI2)
) u_chk (
    .addr      (addr),
    .sw_pol    (sw_pol),
    .size_code (size_code),
    .phi2      (phi2),
    .blk_sel_n (blk_sel_n)
);

// File: tb/sim_blksel_top.sv
module sim_blksel_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [5:0]  sw_pol = 6'b0;
    logic [1:0]  size_code = 2'b00;
    logic        phi2 = 1'b0;
    logic        sel_g_n;
    logic        sel_p_n;
    int          n_checks = 0;
    int          n_fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blksel_top #(.GATE_PHI2(1'b1)) u0 (
        .addr(addr), .sw_pol(sw_pol), .size_code(size_code), .phi2(phi2), .blk_sel_n(sel_g_n)
    );
    blksel_top #(.GATE_PHI2(1'b0)) u1 (
        .addr(addr), .sw_pol(sw_pol), .size_code(size_code), .phi2(phi2), .blk_sel_n(sel_p_n)
    );

    function automatic logic exp_sel(logic [15:0] a, logic [5:0] s, logic [1:0] z, logic p, bit gate);
        int   n = 3 + int'(z);
        logic m = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (a[15-k] != s[5-k]) m = 1'b0;
        end
        if (gate && !p) return 1'b1;
        return ~m;
    endfunction

    task automatic check1(string req, logic got, logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: addr=%h sw=%b size=%b phi2=%b actual=%b expected=%b",
                     req, addr, sw_pol, size_code, phi2, got, exp);
        end
    endtask

    task automatic check_both(string req);
        check1(req, sel_g_n, exp_sel(addr, sw_pol, size_code, phi2, 1'b1));
        check1(req, sel_p_n, exp_sel(addr, sw_pol, size_code, phi2, 1'b0));
    endtask

    task automatic apply(logic [15:0] a, logic [5:0] s, logic [1:0] z, logic p, string req);
        @(posedge clk);
        addr = a; sw_pol = s; size_code = z; phi2 = p;
        @(negedge clk);
        check_both(req);
    endtask

    task automatic run_all();
        logic [15:0] a;
        logic [5:0]  s;
        // reset state: all inputs zero, match true, phase 2 low
        repeat (3) @(posedge clk);
        @(negedge clk);
        check1("R7 reset", sel_g_n, 1'b1);
        check1("R8 reset", sel_p_n, 1'b0);
        rst = 1'b0;

        // R6: 1K select at 0x1000
        apply(16'h0FFF, 6'b000100, 2'b11, 1'b1, "R6 below");
        check1("R6 below", sel_g_n, 1'b1);
        apply(16'h1000, 6'b000100, 2'b11, 1'b1, "R6 first");
        check1("R6 first", sel_g_n, 1'b0);
        apply(16'h13FF, 6'b000100, 2'b11, 1'b1, "R6 last");
        check1("R6 last", sel_g_n, 1'b0);
        apply(16'h1400, 6'b000100, 2'b11, 1'b1, "R6 above");
        check1("R6 above", sel_g_n, 1'b1);

        // R1: same address/switches, each size code
        apply(16'h1400, 6'b000100, 2'b00, 1'b1, "R1 8K");
        check1("R1 8K", sel_g_n, 1'b0);
        apply(16'h1400, 6'b000100, 2'b01, 1'b1, "R1 4K");
        check1("R1 4K", sel_g_n, 1'b0);
        apply(16'h1400, 6'b000100, 2'b10, 1'b1, "R1 2K");
        check1("R1 2K", sel_g_n, 1'b0);
        apply(16'h1400, 6'b000100, 2'b11, 1'b1, "R1 1K");
        check1("R1 1K", sel_g_n, 1'b1);

        // R4: low address lines ignored
        for (int i = 0; i < 40; i++) begin
            a = {3'b101, 13'($urandom)};
            apply(a, 6'b101000, 2'b00, 1'b1, "R4");
            check1("R4", sel_g_n, 1'b0);
        end
        // R5: low switch bits ignored
        for (int i = 0; i < 16; i++) begin
            s = {3'b101, 3'($urandom)};
            apply(16'hA000, s, 2'b00, 1'b1, "R5");
            check1("R5", sel_p_n, 1'b0);
        end

        // R7 and R8: phase-2 behaviour with a matching address
        apply(16'h1000, 6'b000100, 2'b11, 1'b0, "R7 phi2 low");
        check1("R7 phi2 low", sel_g_n, 1'b1);
        check1("R8 phi2 low", sel_p_n, 1'b0);
        apply(16'h1000, 6'b000100, 2'b11, 1'b1, "R7 phi2 high");
        check1("R8 phi2 high", sel_p_n, 1'b0);

        // R9: changes inside one half period, no clock edge
        @(negedge clk);
        addr = 16'h2000; sw_pol = 6'b001000; size_code = 2'b11; phi2 = 1'b1;
        #1 check1("R9 follow", sel_g_n, 1'b0);
        addr = 16'h2400;
        #1 check1("R9 follow", sel_g_n, 1'b1);
        phi2 = 1'b0; addr = 16'h2000;
        #1 check1("R9 follow", sel_g_n, 1'b1);

        // R3: matched address, flip one upper bit, sweep every size
        for (int z = 0; z < 4; z++) begin
            for (int b = 0; b < 6; b++) begin
                for (int r = 0; r < 8; r++) begin
                    s = 6'($urandom);
                    a = {s, 10'($urandom)};
                    a[15-b] = ~a[15-b];
                    apply(a, s, 2'(z), 1'b1, "R3 flip");
                    if (b < 3 + z) check1("R3 flip", sel_p_n, 1'b1);
                    else           check1("R4 flip", sel_p_n, 1'b0);
                end
            end
        end

        // R2: fully random stimulus
        for (int i = 0; i < 3000; i++) begin
            apply(16'($urandom), 6'($urandom), 2'($urandom), 1'($urandom), "R2 random");
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240601);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL R9 watchdog: actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule